// File: doc/BRIEF.md
# ATM Cell Connection Address Compression Lookup

This block maps the connection identifiers of an incoming ATM cell to the word address of that connection's table entry. It uses two stages. In the first stage, the physical port number and the VPI form one identifier. A path mask reduces that identifier to a dense path pointer, and the block reads the path-level table at that pointer. The entry returned carries a valid flag and the offset of one channel-level table. In the second stage, a channel mask reduces the 16-bit VCI to a dense channel pointer. The entry address is then the table base plus four times the offset plus four times the channel pointer.

Compression works the same way at both stages. The block takes the identifier bits at every position where the mask holds a one and packs them next to each other, lowest mask position first. When checking is enabled, an identifier bit set outside its mask marks the cell as misinserted. The cell is also discarded when the path entry is not valid. Every discarded cell produces a one-cycle statistics pulse and advances a saturating counter.

Cells are accepted one at a time on a valid/ready handshake. The masks, the base and the check enable are captured when a cell is accepted.

Top module: `cell_addr_lookup`

## Requirements
- R1: The path pointer on `vpt_addr_o` is made from the identifier {PHY, VPI}, with the VPI in the low VPI_W bits. The identifier bits at the positions where `cfg_vp_mask_i` is 1 are packed contiguously from pointer bit 0 upward, in ascending position order. All higher pointer bits are 0.
- R2: The channel pointer is made from the VCI under `cfg_vc_mask_i` by the same packing rule. For example, mask 0x0037 and VCI 0x0031 give pointer 0x19.
- R3: `res_addr_o` equals base + 4×offset + 4×channel pointer, modulo 2^32. For example, base 0x0084_0000, offset 0x100, mask 0x0037 and VCI 0x0031 give 0x0084_0464.
- R4: In a path-table word, bit 31 is the entry-valid flag and bits 15:0 hold the channel-table offset. When bit 31 is 0, `res_discard_o` is 1.
- R5: When `cfg_check_unused_i` is 1 and either the identifier or the VCI has a 1 outside its mask, `res_discard_o` is 1. When the check is 0, such bits have no effect on the discard flag.
- R6: `cell_ready_o` is 1 only when the block is idle. A cell is accepted on a clock edge where valid and ready are both 1. In the next cycle `vpt_rd_o` is 1 for exactly one cycle. Ready stays 0 until the result is delivered, and valid presented during that time starts nothing.
- R7: `res_valid_o` is 1 for exactly one cycle. That cycle follows the edge at which `vpt_rvalid_i` is sampled 1 while a read is outstanding, and the address and discard flag are valid in that cycle.
- R8: `stat_pulse_o` is 1 together with exactly those results that have discard = 1. `stat_count_o` increases by one in the same cycle, holds at its maximum 2^CNT_W−1, and is cleared to 0 by reset.
- R9: The masks, base and check enable are sampled when the cell is accepted. Later changes to them do not alter that cell's pointer, address or discard flag.
- R10: During and after reset, `cell_ready_o` is 1, and `vpt_rd_o`, `res_valid_o`, `stat_pulse_o` and `stat_count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_valid_i | input | 1 | Cell header present |
| cell_ready_o | output | 1 | Block idle, cell can be taken |
| cell_phy_i | input | PHY_W | Physical port number |
| cell_vpi_i | input | VPI_W | Virtual path identifier |
| cell_vci_i | input | VCI_W | Virtual channel identifier |
| cfg_vp_mask_i | input | PHY_W+VPI_W | Mask for the path identifier |
| cfg_vc_mask_i | input | VCI_W | Mask for the VCI |
| cfg_vct_base_i | input | ADDR_W | Channel table base address |
| cfg_check_unused_i | input | 1 | Enable the check for bits outside the masks |
| vpt_rd_o | output | 1 | Path-table read request |
| vpt_addr_o | output | PHY_W+VPI_W | Path pointer, used as the entry index |
| vpt_rvalid_i | input | 1 | Path-table read data valid |
| vpt_rdata_i | input | 32 | Path-table entry |
| res_valid_o | output | 1 | Result strobe |
| res_addr_o | output | ADDR_W | Channel entry address |
| res_discard_o | output | 1 | Cell to be discarded |
| stat_pulse_o | output | 1 | Statistics update for a discarded cell |
| stat_count_o | output | CNT_W | Saturating count of discarded cells |

## Verification
The masks are tried in several shapes: a dense low field, scattered fields that span the PHY/VPI boundary, a full mask and an empty mask. These tell correct ordered packing apart from plain masking and from a bit-reversed or unshifted gather. Identifiers with stray bits outside the mask are applied once with checking on and once with it off, on both the path and the channel identifier, so each spill source and the enable are shown to matter on their own. An invalid path entry, an address sum that wraps past 2^32 and a late change of configuration separate the discard sources and show when the configuration is sampled. A long run of discarded cells on a narrow counter exposes the saturation point.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned ENTRY_W   = 32;
  localparam int unsigned ENTRY_VLD = 31;
  localparam int unsigned OFS_W     = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } lk_state_e;
endpackage

// File: rtl/bit_gather.sv
module bit_gather #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] out_o,
  output logic         spill_o
);
  localparam int unsigned RW = (W > 1) ? $clog2(W) : 1;

  logic [RW-1:0] rank [W];

  // rank of bit i = number of mask bits below it
  for (genvar i = 0; i < W; i++) begin : g_rank
    localparam logic [W-1:0] BELOW = (i == 0) ? '0 : ({W{1'b1}} >> (W - i));
    assign rank[i] = RW'($countones(mask_i & BELOW));
  end

  always_comb begin
    out_o = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) out_o[rank[i]] = in_i[i];
    end
  end

  assign spill_o = |(in_i & ~mask_i);
endmodule

// File: rtl/vc_addr_calc.sv
module vc_addr_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned PTR_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ofs_b, ptr_b;

  assign ofs_b  = ADDR_W'({ofs_i, 2'b00});
  assign ptr_b  = ADDR_W'({ptr_i, 2'b00});
  assign addr_o = base_i + ofs_b + ptr_b;
endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned ID_W   = 17,
  parameter int unsigned VCI_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_valid_i,
  output logic              cell_ready_o,
  input  logic [ID_W-1:0]   id_i,
  input  logic [VCI_W-1:0]  vci_i,
  input  logic [ID_W-1:0]   vp_mask_i,
  input  logic [VCI_W-1:0]  vc_mask_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              check_i,
  output logic [ID_W-1:0]   cap_id_o,
  output logic [VCI_W-1:0]  cap_vci_o,
  output logic [ID_W-1:0]   cap_vp_mask_o,
  output logic [VCI_W-1:0]  cap_vc_mask_o,
  output logic [ADDR_W-1:0] cap_base_o,
  output logic              vpt_rd_o,
  input  logic              vpt_rvalid_i,
  input  logic              entry_vld_i,
  input  logic              spill_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic              res_discard_o,
  output logic              stat_pulse_o,
  output logic              stat_inc_o
);
  lk_state_e state_q, state_d;
  logic      cap_check_q;
  logic      accept, finish, discard_d;

  assign cell_ready_o = (state_q == ST_IDLE);
  assign accept       = cell_valid_i && cell_ready_o;
  assign vpt_rd_o     = (state_q == ST_READ);
  assign finish       = (state_q == ST_WAIT) && vpt_rvalid_i;
  assign discard_d    = !entry_vld_i || (cap_check_q && spill_i);
  assign stat_inc_o   = finish && discard_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)       state_d = ST_READ;
      ST_READ:                   state_d = ST_WAIT;
      ST_WAIT: if (vpt_rvalid_i) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cap_id_o      <= '0;
      cap_vci_o     <= '0;
      cap_vp_mask_o <= '0;
      cap_vc_mask_o <= '0;
      cap_base_o    <= '0;
      cap_check_q   <= 1'b0;
      res_valid_o   <= 1'b0;
      res_addr_o    <= '0;
      res_discard_o <= 1'b0;
      stat_pulse_o  <= 1'b0;
    end else begin
      state_q      <= state_d;
      res_valid_o  <= finish;
      stat_pulse_o <= stat_inc_o;
      if (accept) begin
        cap_id_o      <= id_i;
        cap_vci_o     <= vci_i;
        cap_vp_mask_o <= vp_mask_i;
        cap_vc_mask_o <= vc_mask_i;
        cap_base_o    <= base_i;
        cap_check_q   <= check_i;
      end
      if (finish) begin
        res_addr_o    <= addr_i;
        res_discard_o <= discard_d;
      end
    end
  end
endmodule

// File: rtl/cell_addr_lookup.sv
module cell_addr_lookup
  import cal_pkg::*;
#(
  parameter int unsigned PHY_W  = 5,
  parameter int unsigned VPI_W  = 12,
  parameter int unsigned VCI_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned ID_W  = PHY_W + VPI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_valid_i,
  output logic              cell_ready_o,
  input  logic [PHY_W-1:0]  cell_phy_i,
  input  logic [VPI_W-1:0]  cell_vpi_i,
  input  logic [VCI_W-1:0]  cell_vci_i,
  input  logic [ID_W-1:0]   cfg_vp_mask_i,
  input  logic [VCI_W-1:0]  cfg_vc_mask_i,
  input  logic [ADDR_W-1:0] cfg_vct_base_i,
  input  logic              cfg_check_unused_i,
  output logic              vpt_rd_o,
  output logic [ID_W-1:0]   vpt_addr_o,
  input  logic              vpt_rvalid_i,
  input  logic [ENTRY_W-1:0] vpt_rdata_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic              res_discard_o,
  output logic              stat_pulse_o,
  output logic [CNT_W-1:0]  stat_count_o
);
  logic [ID_W-1:0]   cap_id, cap_vp_mask;
  logic [VCI_W-1:0]  cap_vci, cap_vc_mask, vc_ptr;
  logic [ADDR_W-1:0] cap_base, addr_calc;
  logic              vp_spill, vc_spill, stat_inc;

  lookup_ctrl #(.ID_W(ID_W), .VCI_W(VCI_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cell_valid_i (cell_valid_i),
    .cell_ready_o (cell_ready_o),
    .id_i         ({cell_phy_i, cell_vpi_i}),
    .vci_i        (cell_vci_i),
    .vp_mask_i    (cfg_vp_mask_i),
    .vc_mask_i    (cfg_vc_mask_i),
    .base_i       (cfg_vct_base_i),
    .check_i      (cfg_check_unused_i),
    .cap_id_o     (cap_id),
    .cap_vci_o    (cap_vci),
    .cap_vp_mask_o(cap_vp_mask),
    .cap_vc_mask_o(cap_vc_mask),
    .cap_base_o   (cap_base),
    .vpt_rd_o     (vpt_rd_o),
    .vpt_rvalid_i (vpt_rvalid_i),
    .entry_vld_i  (vpt_rdata_i[ENTRY_VLD]),
    .spill_i      (vp_spill | vc_spill),
    .addr_i       (addr_calc),
    .res_valid_o  (res_valid_o),
    .res_addr_o   (res_addr_o),
    .res_discard_o(res_discard_o),
    .stat_pulse_o (stat_pulse_o),
    .stat_inc_o   (stat_inc)
  );

  bit_gather #(.W(ID_W)) i_vp_gather (
    .in_i   (cap_id),
    .mask_i (cap_vp_mask),
    .out_o  (vpt_addr_o),
    .spill_o(vp_spill)
  );

  bit_gather #(.W(VCI_W)) i_vc_gather (
    .in_i   (cap_vci),
    .mask_i (cap_vc_mask),
    .out_o  (vc_ptr),
    .spill_o(vc_spill)
  );

  vc_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PTR_W(VCI_W)) i_addr (
    .base_i(cap_base),
    .ofs_i (vpt_rdata_i[OFS_W-1:0]),
    .ptr_i (vc_ptr),
    .addr_o(addr_calc)
  );

  stat_sat_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (stat_inc),
    .cnt_o (stat_count_o)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cell_valid_i,
  input logic             cell_ready_o,
  input logic             vpt_rd_o,
  input logic             vpt_rvalid_i,
  input logic             res_valid_o,
  input logic             res_discard_o,
  input logic             stat_pulse_o,
  input logic [CNT_W-1:0] stat_count_o
);
  AST_ACCEPT_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_i && cell_ready_o |=> vpt_rd_o && !cell_ready_o);  // R6
  AST_READ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpt_rd_o |=> !vpt_rd_o);  // R6
  AST_READ_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpt_rd_o |-> !cell_ready_o);  // R6
  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);  // R7
  AST_STAT_ON_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_pulse_o |-> res_valid_o && res_discard_o);  // R8
  AST_DISCARD_GIVES_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_discard_o |-> stat_pulse_o);  // R8
  AST_COUNT_ONLY_ON_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_count_o != $past(stat_count_o) |-> stat_pulse_o);  // R8
  AST_COUNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &stat_count_o |=> &stat_count_o);  // R8
endmodule

bind cell_addr_lookup cal_checker #(.CNT_W(CNT_W)) i_cal_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cell_valid_i (cell_valid_i),
  .cell_ready_o (cell_ready_o),
  .vpt_rd_o     (vpt_rd_o),
  .vpt_rvalid_i (vpt_rvalid_i),
  .res_valid_o  (res_valid_o),
  .res_discard_o(res_discard_o),
  .stat_pulse_o (stat_pulse_o),
  .stat_count_o (stat_count_o)
);

// File: tb/test_cell_addr_lookup.sv
`timescale 1ns/1ps
module test_cell_addr_lookup;
  localparam int unsigned PHY_W = 5, VPI_W = 12, VCI_W = 16, ADDR_W = 32, CNT_W = 4;
  localparam int unsigned ID_W = PHY_W + VPI_W;

  typedef struct packed {
    logic [PHY_W-1:0]  phy;
    logic [VPI_W-1:0]  vpi;
    logic [VCI_W-1:0]  vci;
    logic [ID_W-1:0]   vpm;
    logic [VCI_W-1:0]  vcm;
    logic [31:0]       base;
    logic              chk;
    logic [31:0]       entry;
    logic [1:0]        dly;
    logic [ID_W-1:0]   exp_ptr;
    logic [31:0]       exp_addr;
    logic              exp_disc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 12'h005, 16'h0031, 17'h0003F, 16'h0037, 32'h0084_0000, 1'b1, 32'h8000_0100, 2'd0, 17'h00005, 32'h0084_0464, 1'b0},
    '{5'h10, 12'h0A0, 16'h1234, 17'h100F0, 16'hFFFF, 32'h1000_0000, 1'b1, 32'h8000_0040, 2'd2, 17'h0001A, 32'h1000_49D0, 1'b0},
    '{5'h00, 12'h103, 16'h0002, 17'h000FF, 16'h000F, 32'h0000_2000, 1'b1, 32'h8000_0001, 2'd1, 17'h00003, 32'h0000_200C, 1'b1},
    '{5'h00, 12'h103, 16'h0002, 17'h000FF, 16'h000F, 32'h0000_2000, 1'b0, 32'h8000_0001, 2'd3, 17'h00003, 32'h0000_200C, 1'b0},
    '{5'h1F, 12'hFFF, 16'h0130, 17'h1FFFF, 16'h00F0, 32'h0000_0000, 1'b1, 32'h8000_FFFF, 2'd0, 17'h1FFFF, 32'h0004_0008, 1'b1},
    '{5'h00, 12'h001, 16'h8001, 17'h00001, 16'h8001, 32'h0000_1000, 1'b0, 32'h0000_0010, 2'd1, 17'h00001, 32'h0000_104C, 1'b1},
    '{5'h00, 12'h000, 16'h0002, 17'h00000, 16'h0003, 32'hFFFF_FFF0, 1'b1, 32'h8000_0004, 2'd0, 17'h00000, 32'h0000_0008, 1'b0},
    '{5'h00, 12'h800, 16'h0000, 17'h00000, 16'h0000, 32'h0000_0100, 1'b1, 32'h8000_0000, 2'd2, 17'h00000, 32'h0000_0100, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cell_valid = 1'b0, check_en = 1'b0, rvalid = 1'b0;
  logic [PHY_W-1:0]  phy = '0;
  logic [VPI_W-1:0]  vpi = '0;
  logic [VCI_W-1:0]  vci = '0;
  logic [ID_W-1:0]   vp_mask = '0;
  logic [VCI_W-1:0]  vc_mask = '0;
  logic [ADDR_W-1:0] base = '0;
  logic [31:0]       rdata = '0;
  logic              cell_ready, vpt_rd, res_valid, res_discard, stat_pulse;
  logic [ID_W-1:0]   vpt_addr;
  logic [ADDR_W-1:0] res_addr;
  logic [CNT_W-1:0]  stat_count;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cell_addr_lookup #(.PHY_W(PHY_W), .VPI_W(VPI_W), .VCI_W(VCI_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W))
  i_cell_addr_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .cell_valid_i(cell_valid), .cell_ready_o(cell_ready),
    .cell_phy_i(phy), .cell_vpi_i(vpi), .cell_vci_i(vci),
    .cfg_vp_mask_i(vp_mask), .cfg_vc_mask_i(vc_mask), .cfg_vct_base_i(base),
    .cfg_check_unused_i(check_en),
    .vpt_rd_o(vpt_rd), .vpt_addr_o(vpt_addr), .vpt_rvalid_i(rvalid), .vpt_rdata_i(rdata),
    .res_valid_o(res_valid), .res_addr_o(res_addr), .res_discard_o(res_discard),
    .stat_pulse_o(stat_pulse), .stat_count_o(stat_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(vec_t v);
    phy = v.phy; vpi = v.vpi; vci = v.vci; vp_mask = v.vpm; vc_mask = v.vcm;
    base = v.base; check_en = v.chk;
  endtask

  // drives one cell, serves the table read, checks the result; optional config change mid-lookup
  task automatic run_cell(vec_t v, bit scramble);
    @(negedge clk);
    load(v);
    check("R6 ready idle", 32'(cell_ready), 32'd1);
    cell_valid = 1'b1;
    @(negedge clk);
    cell_valid = 1'b0;
    check("R6 read strobe", 32'(vpt_rd), 32'd1);
    check("R1 vp pointer", 32'(vpt_addr), 32'(v.exp_ptr));
    check("R6 busy", 32'(cell_ready), 32'd0);
    if (scramble) begin
      vp_mask = ~v.vpm; vc_mask = ~v.vcm; base = ~v.base; check_en = ~v.chk;
      vci = ~v.vci; vpi = ~v.vpi; cell_valid = 1'b1;  // R9 / R6: ignored while busy
    end
    for (int d = 0; d <= int'(v.dly); d++) begin
      @(negedge clk);
      check("R6 no second read", 32'(vpt_rd), 32'd0);
      check("R7 no early result", 32'(res_valid), 32'd0);
      if (scramble) check("R9 vp pointer held", 32'(vpt_addr), 32'(v.exp_ptr));
    end
    cell_valid = 1'b0;
    rvalid = 1'b1; rdata = v.entry;
    @(negedge clk);
    rvalid = 1'b0; rdata = 32'hDEAD_BEEF;
    if (v.exp_disc) exp_cnt = (exp_cnt < (1 << CNT_W) - 1) ? exp_cnt + 1 : exp_cnt;
    check("R7 result valid", 32'(res_valid), 32'd1);
    check("R3 address", res_addr, v.exp_addr);
    check("R4/R5 discard", 32'(res_discard), 32'(v.exp_disc));
    check("R8 stat pulse", 32'(stat_pulse), 32'(v.exp_disc));
    check("R8 count", 32'(stat_count), 32'(exp_cnt));
    @(negedge clk);
    check("R7 single cycle", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", 32'(cell_ready), 32'd1);
    check("R10 read", 32'(vpt_rd), 32'd0);
    check("R10 result", 32'(res_valid), 32'd0);
    check("R10 count", 32'(stat_count), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 vector table
    foreach (VECS[k]) run_cell(VECS[k], 1'b0);

    // R9: config and header changes after acceptance
    run_cell(VECS[0], 1'b1);
    run_cell(VECS[2], 1'b1);

    // R8 saturation at 2^CNT_W-1
    for (int k = 0; k < 14; k++) run_cell(VECS[7], 1'b0);
    check("R8 saturated", 32'(stat_count), 32'((1 << CNT_W) - 1));

    // R10 reset clears counter
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 count cleared", 32'(stat_count), 32'd0);
    check("R10 ready after reset", 32'(cell_ready), 32'd1);
    rst_n = 1'b1;
    exp_cnt = 0;
    run_cell(VECS[1], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule